// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a main-memory port one word wide. Each 32-bit byte address is split into a tag, a line index and an offset within the line. Each of the 64 lines of 16 bytes keeps a valid flag and a tag. A read that hits returns its word in the cycle it is presented. A read that misses holds the processor while all four words of the line are fetched in order, and then completes as a hit.

Every store goes to memory through a small first-in first-out posting queue of four address/data entries. A store therefore finishes in one cycle unless the queue is already full. A store that hits also updates the cached word. For a store that misses, a mode input chooses between two behaviours: fetching the line first and then writing it (allocate), or posting the store to memory only and leaving the cache untouched (write-around). The queue is always emptied before a line fetch begins, so a fetch can never read a stale word from memory. The queue drains whenever the memory port is not busy with a fetch.

Top module: `wt_cache`

## Requirements
- R1: Address fields are tag = bits 31:10, line index = bits 9:4, word within line = bits 3:2. Bits 1:0 do not affect which word is read. Byte address 1200 falls in line 11, and address 1200+1024 shares that line with a different tag.
- R2: After reset every line is invalid, cpu_ready and mem_req are low while idle, and the first read of any address misses.
- R3: A read whose line is valid with a matching tag raises cpu_ready in the same cycle as cpu_req, and cpu_rdata carries the most recently written value of that word.
- R4: A read miss keeps cpu_ready low, then issues exactly four memory reads (mem_we=0) for words 0,1,2,3 of the line in that order, and then returns the requested word.
- R5: A line counts as a hit only when it is valid and its stored tag equals the address tag. An access to the same index with another tag misses and replaces the line.
- R6: A store that hits updates the cached word, and the same address and data reach memory as one write transfer (mem_we=1).
- R7: The posting queue holds 4 entries and drains to memory in issue order. A store completes in one cycle while fewer than 4 entries are pending. A fifth store stalls until an entry drains.
- R8: No line-fetch read is issued while any posted store is still waiting for memory.
- R9: With alloc_on_wmiss=1, a store miss fetches the four words of the line, then writes the word, and later reads of that line hit.
- R10: With alloc_on_wmiss=0, a store miss issues no memory read and leaves the cache unchanged, so a later read of that word misses and returns the stored value.
- R11: The memory port holds mem_req, mem_we, mem_addr and mem_wdata stable until mem_ack. Each cycle with mem_ack high completes exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_on_wmiss | input | 1 | 1: allocate on store miss, 0: write-around |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready on a load |
| cpu_ready | output | 1 | Access completes this cycle; low during a stall |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 write transfer, 0 read transfer |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer completes this cycle |

## Verification
A store that hits can push a new queue entry in the same cycle that mem_ack retires the oldest one. The same cycle can also see a cached word updated while an older posted word drains. The bench provokes this with back-to-back stores under memory latencies of zero to three wait cycles, together with a slow-memory burst that fills the queue. It judges the result by matching every memory write against its own issue-ordered list of stores and by comparing final memory with a reference image. Each line fetch is also checked to start only when the bench's own count of pending stores is zero.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRAIN = 2'd1,
      ST_FILL  = 2'd2
   } cache_state_e;
endpackage

// File: rtl/wt_tag_store.sv
module wt_tag_store #(
   parameter int LINES = 64,
   parameter int TAG_W = 22,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else if (wr_en) valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[wr_idx] <= wr_tag;
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

   // R2: every line is invalid when reset is released
   a_r2_reset_invalid: assert property (@(posedge clk)
      $rose(rst_n) |-> (valid_q == '0));
endmodule

// File: rtl/wt_data_store.sv
module wt_data_store #(
   parameter int LINES  = 64,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(LINES),
   localparam int WORD_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WORD_W-1:0] rd_word,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] word_q [LINES*WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) word_q[{wr_idx, wr_word}] <= wr_data;
   end

   assign rd_data = word_q[{rd_idx, rd_word}];
endmodule

// File: rtl/wt_write_buffer.sv
module wt_write_buffer #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data,
   output logic              full,
   output logic              empty,
   output logic [CNT_W-1:0]  count
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("wt_write_buffer: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic              held_q;
      logic [ADDR_W-1:0] addr_q;
      logic [DATA_W-1:0] data_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) held_q <= 1'b0;
         else if (push) held_q <= 1'b1;
         else if (pop) held_q <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (push) begin
            addr_q <= push_addr;
            data_q <= push_data;
         end
      end

      assign head_addr = addr_q;
      assign head_data = data_q;
      assign full      = held_q;
      assign empty     = !held_q;
      assign count     = CNT_W'(held_q);
   end else begin : g_ring
      localparam int PTR_W = $clog2(DEPTH);
      logic [ADDR_W-1:0] addr_q [DEPTH];
      logic [DATA_W-1:0] data_q [DEPTH];
      logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
      logic [CNT_W-1:0]  cnt_q;

      function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
         return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
      endfunction

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
         end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
         end
      end

      assign head_addr = addr_q[rd_ptr_q];
      assign head_data = data_q[rd_ptr_q];
      assign full      = (cnt_q == CNT_W'(DEPTH));
      assign empty     = (cnt_q == '0);
      assign count     = cnt_q;
   end

   // R7: the caller never pushes into a full queue nor pops an empty one
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
endmodule

// File: rtl/wt_cache.sv
module wt_cache
   import wt_cache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINES      = 64,
   parameter int LINE_BYTES = 16,
   parameter int WB_DEPTH   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_on_wmiss,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int BYTE_W = $clog2(DATA_W / 8);
   localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
   localparam int WORD_W = $clog2(WORDS);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int LINE_W = TAG_W + IDX_W;
   localparam int CNT_W  = $clog2(WB_DEPTH + 1);

   if ((LINES & (LINES - 1)) != 0 || LINES < 2) begin : g_bad_lines
      $error("wt_cache: LINES must be a power of two of at least 2");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || WORDS < 2) begin : g_bad_line
      $error("wt_cache: a line must be a power of two holding at least 2 words");
   end
   if (DATA_W % 8 != 0 || TAG_W < 1) begin : g_bad_width
      $error("wt_cache: address or data width does not fit the geometry");
   end

   // address fields
   logic [TAG_W-1:0]  cpu_tag;
   logic [IDX_W-1:0]  cpu_idx;
   logic [WORD_W-1:0] cpu_word;
   assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
   assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
   assign cpu_word = cpu_addr[BYTE_W +: WORD_W];

   cache_state_e      state_q;
   logic [LINE_W-1:0] fill_line_q;
   logic [WORD_W-1:0] fill_cnt_q;

   logic              lk_valid, hit, idle, fill_act;
   logic [TAG_W-1:0]  lk_tag;
   logic              want_fill, wb_push, wb_pop, wb_full, wb_empty;
   logic              fill_beat, fill_last;
   logic [ADDR_W-1:0] wb_head_addr;
   logic [DATA_W-1:0] wb_head_data;
   logic [CNT_W-1:0]  wb_count;
   logic              ds_we;
   logic [IDX_W-1:0]  ds_widx;
   logic [WORD_W-1:0] ds_wword;
   logic [DATA_W-1:0] ds_wdata;

   assign idle      = (state_q == ST_IDLE);
   assign fill_act  = (state_q == ST_FILL);
   assign hit       = lk_valid && (lk_tag == cpu_tag);
   assign want_fill = idle && cpu_req && !hit && (!cpu_we || alloc_on_wmiss);
   assign wb_push   = idle && cpu_req && cpu_we && !wb_full && (hit || !alloc_on_wmiss);
   assign cpu_ready = idle && cpu_req && (cpu_we ? (!wb_full && (hit || !alloc_on_wmiss)) : hit);

   assign fill_beat = fill_act && mem_ack;
   assign fill_last = fill_beat && (fill_cnt_q == WORD_W'(WORDS - 1));
   assign wb_pop    = !fill_act && !wb_empty && mem_ack;

   // memory port: line fetch has the port while filling, the posting queue otherwise
   assign mem_req   = fill_act || !wb_empty;
   assign mem_we    = !fill_act;
   assign mem_addr  = fill_act ? {fill_line_q, fill_cnt_q, {BYTE_W{1'b0}}} : wb_head_addr;
   assign mem_wdata = wb_head_data;

   // data store write port: fill beats or store hits
   assign ds_we    = fill_beat || (wb_push && hit);
   assign ds_widx  = fill_act ? fill_line_q[IDX_W-1:0] : cpu_idx;
   assign ds_wword = fill_act ? fill_cnt_q : cpu_word;
   assign ds_wdata = fill_act ? mem_rdata : cpu_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         fill_line_q <= '0;
         fill_cnt_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (want_fill) begin
               fill_line_q <= {cpu_tag, cpu_idx};
               fill_cnt_q  <= '0;
               state_q     <= wb_empty ? ST_FILL : ST_DRAIN;
            end
            ST_DRAIN: if (wb_empty) state_q <= ST_FILL;
            ST_FILL: if (fill_beat) begin
               fill_cnt_q <= fill_cnt_q + 1'b1;
               if (fill_last) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   wt_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (cpu_idx),
      .rd_valid (lk_valid),
      .rd_tag   (lk_tag),
      .wr_en    (fill_last),
      .wr_idx   (fill_line_q[IDX_W-1:0]),
      .wr_tag   (fill_line_q[LINE_W-1 -: TAG_W])
   );

   wt_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .rd_idx  (cpu_idx),
      .rd_word (cpu_word),
      .rd_data (cpu_rdata),
      .wr_en   (ds_we),
      .wr_idx  (ds_widx),
      .wr_word (ds_wword),
      .wr_data (ds_wdata)
   );

   wt_write_buffer #(.DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wb_push),
      .push_addr (cpu_addr),
      .push_data (cpu_wdata),
      .pop       (wb_pop),
      .head_addr (wb_head_addr),
      .head_data (wb_head_data),
      .full      (wb_full),
      .empty     (wb_empty),
      .count     (wb_count)
   );

   // R8: a line fetch only starts once the posting queue reports empty
   a_r8_fill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fill_act) |-> (wb_empty && wb_count == '0));
   // R11: a pending memory request keeps its fields until acknowledged
   a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                 && $stable(mem_wdata)));
   // R10: a write-around store miss never starts a fetch
   a_r10_around_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && cpu_req && cpu_we && !alloc_on_wmiss) |=> !fill_act);
   // R4: the last fetch beat returns the controller to idle
   a_r4_fill_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
      fill_last |=> (state_q == ST_IDLE));
endmodule

// File: tb/tb_wt_cache.sv
module tb_wt_cache;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_on_wmiss = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_ready;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   wt_cache dut (
      .clk(clk), .rst_n(rst_n), .alloc_on_wmiss(alloc_on_wmiss),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   int tests = 0, fails = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- bench memory and reference image ----------------
   logic [31:0] mem_img [int unsigned];
   logic [31:0] ref_img [int unsigned];
   int unsigned wr_q_addr [$];
   logic [31:0] wr_q_data [$];
   int mem_wait = 0, wcnt = 0, rd_beats = 0, pending = 0, fill_word = 0;
   bit hold_seen = 0;
   logic [31:0] hold_addr;

   function automatic logic [31:0] seed_val(input int unsigned wa);
      return (wa * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
   endfunction
   function automatic logic [31:0] img_rd(input int unsigned wa);
      return mem_img.exists(wa) ? mem_img[wa] : seed_val(wa);
   endfunction
   function automatic logic [31:0] ref_rd(input int unsigned wa);
      return ref_img.exists(wa) ? ref_img[wa] : seed_val(wa);
   endfunction

   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req && rst_n) begin
         if (hold_seen)  // R11: fields held while waiting
            check(mem_addr == hold_addr, "R11", "mem_addr held", mem_addr, hold_addr);
         if (wcnt >= mem_wait) begin
            wcnt = 0;
            hold_seen = 0;
            mem_ack <= 1'b1;
            if (mem_we) begin
               img_wr(mem_addr, mem_wdata);
            end else begin
               rd_beats++;
               // R8: no fetch while a posted store is pending
               check(pending == 0, "R8", "pending stores at fetch", pending, 0);
               // R4: fetch beats in ascending word order
               check(mem_addr[3:2] == fill_word[1:0], "R4", "fetch word order",
                     mem_addr[3:2], fill_word[1:0]);
               fill_word = (fill_word + 1) % 4;
               mem_rdata <= img_rd(mem_addr >> 2);
            end
         end else begin
            wcnt++;
            hold_seen = 1;
            hold_addr = mem_addr;
         end
      end
   end

   task automatic img_wr(input logic [31:0] a, input logic [31:0] d);
      pending--;
      mem_img[a >> 2] = d;
      if (wr_q_addr.size() == 0) begin
         check(0, "R7", "unexpected memory write", a, 0);
      end else begin
         // R6/R7: writes reach memory in issue order with their data
         check(wr_q_addr[0] == (a >> 2), "R7", "write order addr", a >> 2, wr_q_addr[0]);
         check(wr_q_data[0] == d, "R6", "write data", d, wr_q_data[0]);
         void'(wr_q_addr.pop_front());
         void'(wr_q_data.pop_front());
      end
   endtask

   // ---------------- bench model of cache contents ----------------
   bit          mv [64];
   logic [21:0] mt [64];

   function automatic logic [31:0] mk(input int tag, input int idx, input int wd);
      return {22'(tag), 6'(idx), 2'(wd), 2'b00};
   endfunction

   task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                         input bit alloc, output logic [31:0] rd, output int cyc);
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; alloc_on_wmiss = alloc;
      cyc = 0;
      forever begin
         #1;
         cyc++;
         if (cpu_ready) break;
         @(negedge clk);
      end
      rd = cpu_rdata;
      @(posedge clk);
      if (we) begin
         pending++;
         wr_q_addr.push_back(a >> 2);
         wr_q_data.push_back(d);
         ref_img[a >> 2] = d;
      end
      #1 cpu_req = 0;
   endtask

   // one access with full prediction of hit/miss behaviour
   task automatic op(input bit we, input logic [31:0] a, input logic [31:0] d, input bit alloc);
      logic [31:0] rd, expv;
      int cyc, r0, idx;
      bit h;
      idx = a[9:4];
      h = mv[idx] && (mt[idx] == a[31:10]);   // R5 hit rule
      expv = ref_rd(a >> 2);
      r0 = rd_beats;
      fill_word = 0;
      access(we, a, d, alloc, rd, cyc);
      if (!we) begin
         check(rd == expv, h ? "R3" : "R4", "load data", rd, expv);
         if (h) begin
            check(cyc == 1, "R3", "hit latency", cyc, 1);
            check(rd_beats - r0 == 0, "R5", "no fetch on hit", rd_beats - r0, 0);
         end else begin
            check(cyc > 1, "R4", "miss stalls", cyc, 2);
            check(rd_beats - r0 == 4, "R4", "fetch beats", rd_beats - r0, 4);
            mv[idx] = 1; mt[idx] = a[31:10];
         end
      end else if (h) begin
         check(rd_beats - r0 == 0, "R6", "store hit fetch beats", rd_beats - r0, 0);
      end else if (alloc) begin
         check(rd_beats - r0 == 4, "R9", "allocate fetch beats", rd_beats - r0, 4);
         mv[idx] = 1; mt[idx] = a[31:10];
      end else begin
         check(rd_beats - r0 == 0, "R10", "write-around fetch beats", rd_beats - r0, 0);
      end
   endtask

   task automatic wait_drain();
      for (int i = 0; i < 2000 && pending != 0; i++) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int cyc;
      void'($urandom(32'd1234));
      for (int i = 0; i < 64; i++) mv[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R2: quiet after reset
      check(cpu_ready == 0, "R2", "ready idle after reset", cpu_ready, 0);
      check(mem_req == 0, "R2", "mem_req idle after reset", mem_req, 0);
      op(0, mk(0, 0, 0), 0, 0);            // R2: first read misses
      op(0, mk(5, 63, 3), 0, 0);           // R2: top index misses too

      // R1: address 1200 -> line 11, offset bits ignored
      check(32'd1200 >> 4 == 32'd75 && 32'(75 % 64) == 32'd11, "R1", "line of 1200", (1200 >> 4) % 64, 11);
      op(1, 32'd1200, 32'hCAFE_0001, 1);   // R9 allocate
      op(0, 32'd1201, 0, 0);               // R1: byte bits do not matter, hit
      op(0, 32'd1200 + 32'd1024, 0, 0);    // R1/R5: same line other tag, miss
      op(0, 32'd1200, 0, 0);               // R5: replaced, miss again
      op(0, 32'd1204, 0, 0);               // R3: neighbour word hits

      // R6: store hit then read back
      op(1, 32'd1208, 32'h1234_5678, 0);
      op(0, 32'd1208, 0, 0);

      // R10 / R8: write-around then load
      op(1, mk(9, 20, 1), 32'hBEEF_0010, 0);
      op(0, mk(9, 20, 1), 0, 0);

      // R7: queue full stall with slow memory
      wait_drain();
      mem_wait = 30;
      for (int k = 0; k < 5; k++) begin
         access(1, mk(40 + k, 30, 0), 32'hA000_0000 + k, 0, rd, cyc);
         if (k < 4) check(cyc == 1, "R7", "store posts in one cycle", cyc, 1);
         else       check(cyc > 1, "R7", "fifth store stalls", cyc, 2);
      end
      wait_drain();
      check(pending == 0, "R7", "queue drained", pending, 0);
      mem_wait = 0;

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         if (n % 50 == 0) mem_wait = $urandom_range(0, 3);
         op($urandom_range(0, 2) == 0 ? 1'b1 : 1'b0,
            mk($urandom_range(0, 2), $urandom_range(0, 7), $urandom_range(0, 3)),
            $urandom, $urandom_range(0, 1));
      end

      // R6: final memory image equals reference
      wait_drain();
      foreach (ref_img[k])
         check(img_rd(k) == ref_img[k], "R6", "final memory word", img_rd(k), ref_img[k]);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule